// File: doc/BRIEF.md
# Bit-Pattern and Shift Operation Unit

This unit applies one chosen bit operation to an operand word A and stores the outcome in a result register. The second operand, B, acts as a bit pattern: it marks which positions of A are forced high, inverted or forced low, which positions survive a mask, or which field is replaced by an insert value. The unit also offers an equality compare that leaves the XOR of the operands in the result register and records whether they matched. It provides logical, rotating and sign-preserving shifts by one place in either direction.

A controller presents the operation code, A, B and the insert value together with a load strobe. On a clock edge with the strobe high, the result, the equality flag and the shift overflow flag are updated as the operation defines. With the strobe low, all three hold. The reset input clears the registers at once, and its release is synchronised inside the block.

Top module: `lsu_top`

## Requirements
- R1: Operation code 0 (selective set) loads A OR B: every bit where B is 1 becomes 1, the others copy A.
- R2: Operation code 1 (selective complement) loads A XOR B: bits where B is 1 are inverted, the others copy A.
- R3: Operation code 2 (selective clear) loads A AND NOT B: bits where B is 1 become 0, the others copy A.
- R4: Operation code 3 (mask) loads A AND B: bits where B is 0 become 0.
- R5: Operation code 4 (insert) loads (A AND NOT B) OR (insert value AND B): B marks the field, which is cleared and then filled from the insert value. Insert-value bits outside the field have no effect.
- R6: Operation code 5 (compare) loads A XOR B and sets the equality flag to 1 exactly when A equals B. No other operation changes the equality flag.
- R7: Operation codes 6 and 7 shift A one place left or right, with 0 entering the vacated end.
- R8: Operation codes 8 and 9 rotate A one place left or right, and the bit leaving one end enters the other end.
- R9: Operation code 11 (arithmetic right shift) keeps the MSB, copies it into the next lower bit and drops bit 0.
- R10: Operation code 10 (arithmetic left shift) enters 0 at bit 0 and drops the old MSB. It sets the overflow flag to 1 when the old MSB and the new MSB differ. Every other loaded operation code from 0 to 9 or 11 clears the overflow flag.
- R11: With the load strobe low, the result, the equality flag and the overflow flag keep their values.
- R12: Operation codes 12 to 15 change none of the registers, even with the load strobe high.
- R13: After reset, the result, the equality flag and the overflow flag are 0. A loaded operation is visible on the outputs after the first rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_i | input | 1 | Load strobe; the registers update only when it is high |
| op_i | input | 4 | Operation code |
| a_i | input | W | Operand A |
| b_i | input | W | Bit pattern B |
| ins_i | input | W | Insert value |
| res_o | output | W | Registered result |
| eq_o | output | 1 | Registered equality flag |
| ovf_o | output | 1 | Registered arithmetic left shift overflow flag |

## Verification
Every result is due exactly one rising edge after the load is presented: the result, the equality flag and the overflow flag are each a single register stage. The bench drives its inputs on the falling edge and checks all three outputs on the next falling edge, after exactly one capturing edge. It keeps its own copy of the flags so that hold cycles, unused codes and operations that leave the equality flag alone are checked against the values that should persist. After reset is released, two more edges pass before the first load, to allow for the internal reset synchroniser.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [3:0] {
    OP_SSET  = 4'd0,
    OP_SCOMP = 4'd1,
    OP_SCLR  = 4'd2,
    OP_MASK  = 4'd3,
    OP_INS   = 4'd4,
    OP_CMP   = 4'd5,
    OP_SHL   = 4'd6,
    OP_SHR   = 4'd7,
    OP_ROL   = 4'd8,
    OP_ROR   = 4'd9,
    OP_ASL   = 4'd10,
    OP_ASR   = 4'd11
  } lsu_op_e;
endpackage

// File: rtl/lsu_bitwise.sv
module lsu_bitwise
  import lsu_pkg::*;
#(
  parameter int W = 8
) (
  input  lsu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  ins,
  output logic [W-1:0]  y,
  output logic          hit,
  output logic          is_cmp
);
  // per-bit cell: each result bit depends only on the same position of the inputs
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (op)
        OP_SSET:  y[i] = a[i] | b[i];
        OP_SCOMP: y[i] = a[i] ^ b[i];
        OP_SCLR:  y[i] = a[i] & ~b[i];
        OP_MASK:  y[i] = a[i] & b[i];
        OP_INS:   y[i] = (a[i] & ~b[i]) | (ins[i] & b[i]);
        OP_CMP:   y[i] = a[i] ^ b[i];
        default:  y[i] = a[i];
      endcase
    end
  end

  always_comb begin
    hit    = (op == OP_SSET) || (op == OP_SCOMP) || (op == OP_SCLR) ||
             (op == OP_MASK) || (op == OP_INS)   || (op == OP_CMP);
    is_cmp = (op == OP_CMP);
  end
endmodule

// File: rtl/lsu_shift.sv
module lsu_shift
  import lsu_pkg::*;
#(
  parameter int W = 8
) (
  input  lsu_op_e       op,
  input  logic [W-1:0]  a,
  output logic [W-1:0]  y,
  output logic          ovf,
  output logic          hit
);
  localparam int MSB = W - 1;

  always_comb begin
    y   = a;
    ovf = 1'b0;
    hit = 1'b1;
    unique case (op)
      OP_SHL: y = {a[MSB-1:0], 1'b0};
      OP_SHR: y = {1'b0, a[MSB:1]};
      OP_ROL: y = {a[MSB-1:0], a[MSB]};
      OP_ROR: y = {a[0], a[MSB:1]};
      OP_ASL: begin
        y   = {a[MSB-1:0], 1'b0};
        ovf = a[MSB] ^ a[MSB-1];
      end
      OP_ASR: y = {a[MSB], a[MSB:1]};
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  ins_i,
  output logic [W-1:0]  res_o,
  output logic          eq_o,
  output logic          ovf_o
);
  localparam int SYNC_STAGES = 2;

  lsu_op_e op;
  assign op = lsu_op_e'(op_i);

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rsync_q[SYNC_STAGES-1];

  logic [W-1:0] log_y, sh_y;
  logic         log_hit, log_cmp, sh_hit, sh_ovf;

  lsu_bitwise #(.W(W)) u_bitwise (
    .op(op), .a(a_i), .b(b_i), .ins(ins_i),
    .y(log_y), .hit(log_hit), .is_cmp(log_cmp)
  );

  lsu_shift #(.W(W)) u_shift (
    .op(op), .a(a_i), .y(sh_y), .ovf(sh_ovf), .hit(sh_hit)
  );

  logic [W-1:0] res_q, res_d;
  logic         eq_q, eq_d, ovf_q, ovf_d, en;

  assign en = ld_i & (log_hit | sh_hit);

  always_comb begin
    res_d = res_q;
    eq_d  = eq_q;
    ovf_d = ovf_q;
    if (log_hit) begin
      res_d = log_y;
      ovf_d = 1'b0;
      if (log_cmp) eq_d = ~|log_y;
    end else if (sh_hit) begin
      res_d = sh_y;
      ovf_d = sh_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      eq_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else if (en) begin
      res_q <= res_d;
      eq_q  <= eq_d;
      ovf_q <= ovf_d;
    end
  end

  assign res_o = res_q;
  assign eq_o  = eq_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_i,
  input logic [3:0]    op_i,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [W-1:0]  res_o,
  input logic          eq_o,
  input logic          ovf_o
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(res_o) && $stable(eq_o) && $stable(ovf_o));

  a_r12_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && op_i >= 4'd12) |=> $stable(res_o) && $stable(eq_o) && $stable(ovf_o));

  a_r6_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && op_i == 4'd5) |=> eq_o == ($past(a_i) == $past(b_i)));

  a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && op_i == 4'd0) |=> (res_o & $past(b_i)) == $past(b_i));

  a_r9_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && op_i == 4'd11) |=>
      res_o[W-1] == $past(a_i[W-1]) && res_o[W-2] == $past(a_i[W-1]));

  a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && op_i == 4'd10) |=>
      ovf_o == ($past(a_i[W-1]) ^ $past(a_i[W-2])) && !res_o[0]);

  a_r8_rot_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && (op_i == 4'd8 || op_i == 4'd9)) |=>
      $countones(res_o) == $countones($past(a_i)));
endmodule

bind lsu_top lsu_checker #(.W(W)) u_lsu_checker (
  .clk(clk), .rst_n(rst_sync_n), .ld_i(ld_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .res_o(res_o), .eq_o(eq_o), .ovf_o(ovf_o)
);

// File: tb/lsu_top_test.sv
`timescale 1ns/1ps
module lsu_top_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_i = 1'b0;
  logic [3:0]   op_i = 4'd0;
  logic [W-1:0] a_i = '0, b_i = '0, ins_i = '0;
  logic [W-1:0] res_o;
  logic         eq_o, ovf_o;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] exp_res = '0;
  logic         exp_eq  = 1'b0;
  logic         exp_ovf = 1'b0;

  always #5 clk = ~clk;

  lsu_top #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .ins_i(ins_i),
    .res_o(res_o), .eq_o(eq_o), .ovf_o(ovf_o)
  );

  function automatic string tag_of(input logic [3:0] op, input logic ld);
    if (!ld) return "R11";
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      4'd10: return "R10";
      4'd11: return "R9";
      default: return "R12";
    endcase
  endfunction

  // expected result for codes 0..11
  function automatic logic [W-1:0] calc(input logic [3:0] op,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] ins);
    case (op)
      4'd0:  return a | b;
      4'd1:  return a ^ b;
      4'd2:  return a & ~b;
      4'd3:  return a & b;
      4'd4:  return (a & ~b) | (ins & b);
      4'd5:  return a ^ b;
      4'd6:  return a << 1;
      4'd7:  return a >> 1;
      4'd8:  return (a << 1) | (a >> (W-1));
      4'd9:  return (a >> 1) | (a << (W-1));
      4'd10: return a << 1;
      default: return (a >> 1) | (a & (1 << (W-1)));
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic ld, input logic [3:0] op,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] ins);
    string t;
    ld_i = ld; op_i = op; a_i = a; b_i = b; ins_i = ins;
    if (ld && op < 4'd12) begin
      exp_res = calc(op, a, b, ins);
      exp_ovf = (op == 4'd10) ? (a[W-1] ^ a[W-2]) : 1'b0;
      if (op == 4'd5) exp_eq = (a == b);
    end
    @(negedge clk);
    t = tag_of(op, ld);
    check(t, "result", res_o, exp_res);
    check(t, "eq", {{(W-1){1'b0}}, eq_o}, {{(W-1){1'b0}}, exp_eq});
    check(t, "ovf", {{(W-1){1'b0}}, ovf_o}, {{(W-1){1'b0}}, exp_ovf});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R13", "reset result", res_o, '0);
    check("R13", "reset eq", {7'd0, eq_o}, 8'd0);
    check("R13", "reset ovf", {7'd0, ovf_o}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // directed corner cases
    apply(1, 4'd0, 8'h0F, 8'hC0, 8'h00);   // R1
    apply(1, 4'd1, 8'hAA, 8'hF0, 8'h00);   // R2
    apply(1, 4'd2, 8'hFF, 8'h81, 8'h00);   // R3
    apply(1, 4'd3, 8'h6A, 8'hF0, 8'h00);   // R4
    apply(1, 4'd4, 8'h6A, 8'hF0, 8'h9F);   // R5: outside bits of ins ignored
    apply(1, 4'd5, 8'h3C, 8'h3C, 8'h00);   // R6 equal
    apply(1, 4'd0, 8'h01, 8'h02, 8'h00);   // R6 eq kept by other op
    apply(1, 4'd5, 8'h3C, 8'h3D, 8'h00);   // R6 unequal
    apply(1, 4'd6, 8'h81, 8'h00, 8'h00);   // R7
    apply(1, 4'd7, 8'h81, 8'h00, 8'h00);   // R7
    apply(1, 4'd8, 8'h81, 8'h00, 8'h00);   // R8
    apply(1, 4'd9, 8'h81, 8'h00, 8'h00);   // R8
    apply(1, 4'd11, 8'h92, 8'h00, 8'h00);  // R9 negative
    apply(1, 4'd11, 8'h41, 8'h00, 8'h00);  // R9 positive
    apply(1, 4'd10, 8'h40, 8'h00, 8'h00);  // R10 overflow
    apply(0, 4'd0, 8'h00, 8'hFF, 8'h00);   // R11 hold keeps ovf
    apply(1, 4'd13, 8'h55, 8'h55, 8'h55);  // R12 unused code
    apply(1, 4'd10, 8'hC0, 8'h00, 8'h00);  // R10 no overflow
    apply(1, 4'd10, 8'h80, 8'h00, 8'h00);  // R10 overflow
    apply(1, 4'd3, 8'hFF, 8'hFF, 8'h00);   // R10 cleared by other op
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      logic       ld;
      op = 4'($urandom_range(0, 15));
      ld = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 5) == 0) apply(ld, 4'd5, 8'hA5, 8'hA5, 8'h00);
      else apply(ld, op, 8'($urandom), 8'($urandom), 8'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1ms;
    checks++;
    fails++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule